// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Unit

This unit is the interrupt reporting slice of a SCSI bus controller. It holds three registers that the host sees: an interrupt-cause byte, a status byte whose top bit marks an interrupt as pending, and a three-bit sequence-step value. It drives one registered, active-high interrupt line. Internal events inside the controller merge cause and status bits and raise the line. Bus-reset and selection-control commands also update the cause byte. Whether a bus-reset command raises the line depends on a configuration input that disables reset reporting.

The host acknowledges an interrupt by reading the cause byte. The read returns the current value and has side effects. It zeroes the cause byte, clears the terminal-count and pending bits of the status byte, loads the sequence step with the command-done code and drops the line.

A command-completion report can arrive while an earlier interrupt is still unread. The unit then parks its status code in a one-entry slot instead of overwriting the host-visible state. The same acknowledging read that clears the old interrupt posts the parked completion, so the line rises again on the next cycle.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the cause byte, status byte, sequence step and completion code are all zero, the deferred flag is low and `irq` is low.
- R2: `irq` is a register that follows status bit 7 (interrupt pending). It goes high on the clock edge that applies a raising action and stays high until an acknowledging read.
- R3: While `rd_cause` is high, `rd_data` shows the current cause byte. After that edge the cause byte reads zero, unless an action applied in the same cycle writes it.
- R4: An acknowledging read clears status bits 7 and 4 (terminal count), keeps status bits 6:5 and 3:0, and loads the sequence step with 3'b100 (command done).
- R5: An internal event (`ev_set`) ORs `ev_cause` into the cause byte and `ev_stat` into status bits 6:0, and raises the interrupt.
- R6: A completion (`cmpl_valid`) that arrives while status bit 7 is set does not change cause, status or sequence step. It sets `defer_pending` and stores `cmpl_status`.
- R7: A completion reported at once sets status to 8'h93 (pending, terminal count, status phase 3'b011), cause to 8'h10 (bus service) and sequence step to 3'b000, and copies the status code to `cmpl_code`.
- R8: An acknowledging read while `defer_pending` is high first clears, then reports the stored completion as in R7 within the same edge. `defer_pending` then falls and `irq` is high on the next cycle.
- R9: Command 2'b01 (bus reset) sets the cause byte to 8'h80. It raises the interrupt only when `rpt_dis` is low.
- R10: Command 2'b11 (disable selection) zeroes the cause byte and raises the interrupt. Command 2'b10 (enable selection) only zeroes the cause byte. Command 2'b00 changes nothing.
- R11: Actions in one cycle apply in this order: read, replay of a deferred completion, new completion, command, event. A raise in the same cycle as a read therefore leaves the interrupt pending.
- R12: A completion in the same cycle as a read with nothing deferred is reported at once and not deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cause | input | 1 | Host read of the cause byte (acknowledge) |
| ev_set | input | 1 | Internal event strobe |
| ev_cause | input | 8 | Cause bits merged by an event |
| ev_stat | input | 7 | Status bits 6:0 merged by an event |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 00 none, 01 bus reset, 10 enable selection, 11 disable selection |
| rpt_dis | input | 1 | Configuration: suppress the interrupt of a bus reset |
| cmpl_valid | input | 1 | Command-completion strobe |
| cmpl_status | input | 8 | Status code of the completion |
| irq | output | 1 | Registered, active-high interrupt line |
| rd_data | output | 8 | Cause byte as returned by a read |
| status | output | 8 | Status byte |
| seq_step | output | 3 | Sequence-step value |
| cmpl_code | output | 8 | Status code of the last reported completion |
| defer_pending | output | 1 | A completion is parked |

## Verification
The acknowledging read can fall in the same cycle as a new raise: an event, a completion or a bus-reset or disable-selection command. The read can also meet a parked completion, which is the read/replay collision. The bench provokes both on purpose. In directed steps it asserts `rd_cause` together with `ev_set` or `cmpl_valid`, and together with a stored completion. A long pseudo-random phase then mixes every strobe, including completion capture in the same cycle as a replay. A behavioural model applies the fixed order of R11 to each edge, and every output is compared with it on every cycle.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int DATA_W       = 8;
    localparam int SEQ_W        = 3;
    localparam int PHASE_W      = 3;
    localparam int STAT_INT_BIT = 7;
    localparam int STAT_TC_BIT  = 4;

    localparam logic [PHASE_W-1:0] PHASE_STATUS = 3'b011;
    localparam logic [DATA_W-1:0]  CAUSE_RST    = 8'h80;
    localparam logic [DATA_W-1:0]  CAUSE_BSVC   = 8'h10;
    localparam logic [SEQ_W-1:0]   SEQ_DONE     = 3'b100;
    localparam logic [SEQ_W-1:0]   SEQ_IDLE     = 3'b000;

    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_BUS_RST = 2'b01,
        OP_SEL_EN  = 2'b10,
        OP_SEL_DIS = 2'b11
    } cmd_op_e;

    typedef struct packed {
        logic clr_cause;
        logic set_rst;
        logic raise;
    } cmd_act_t;

    typedef struct packed {
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] stat;
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] code;
        logic              irq;
    } isu_state_t;
endpackage

// File: rtl/isu_cmd_decode.sv
module isu_cmd_decode
    import isu_pkg::*;
(
    input  logic     cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic     rpt_dis,
    output cmd_act_t act
);
    always_comb begin
        act = '0;
        if (cmd_valid) begin
            unique case (cmd_op_e'(cmd_op))
                OP_BUS_RST: begin
                    act.set_rst = 1'b1;
                    act.raise   = ~rpt_dis;
                end
                OP_SEL_EN:  act.clr_cause = 1'b1;
                OP_SEL_DIS: begin
                    act.clr_cause = 1'b1;
                    act.raise     = 1'b1;
                end
                default: act = '0;
            endcase
        end
    end
endmodule

// File: rtl/isu_defer_slot.sv
module isu_defer_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         release_i,
    input  logic [W-1:0] cap_status,
    output logic         pend_q,
    output logic [W-1:0] stat_q
);
    logic         pend_d;
    logic [W-1:0] stat_d;

    always_comb begin
        pend_d = pend_q;
        stat_d = stat_q;
        if (capture) begin
            pend_d = 1'b1;
            stat_d = cap_status;
        end else if (release_i) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            stat_q <= '0;
        end else begin
            pend_q <= pend_d;
            stat_q <= stat_d;
        end
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_cause,
    input  logic       ev_set,
    input  logic [7:0] ev_cause,
    input  logic [6:0] ev_stat,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       rpt_dis,
    input  logic       cmpl_valid,
    input  logic [7:0] cmpl_status,
    output logic       irq,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic [2:0] seq_step,
    output logic [7:0] cmpl_code,
    output logic       defer_pending
);
    isu_state_t        st_d, st_q;
    cmd_act_t          act;
    logic              slot_pend_q;
    logic [DATA_W-1:0] slot_stat_q;
    logic              capture, release_s;

    localparam logic [DATA_W-1:0] REPORT_STAT =
        DATA_W'((1 << STAT_INT_BIT) | (1 << STAT_TC_BIT)) | DATA_W'(PHASE_STATUS);

    isu_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .rpt_dis   (rpt_dis),
        .act       (act)
    );

    isu_defer_slot #(.W(DATA_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .release_i  (release_s),
        .cap_status (cmpl_status),
        .pend_q     (slot_pend_q),
        .stat_q     (slot_stat_q)
    );

    assign release_s = rd_cause & slot_pend_q;

    // Next-state: read first, then replay, completion, command, event.
    always_comb begin
        st_d    = st_q;
        capture = 1'b0;

        if (rd_cause) begin
            st_d.cause               = '0;
            st_d.stat[STAT_TC_BIT]   = 1'b0;
            st_d.stat[STAT_INT_BIT]  = 1'b0;
            st_d.seq                 = SEQ_DONE;
            if (slot_pend_q) begin
                st_d.stat  = REPORT_STAT;
                st_d.cause = CAUSE_BSVC;
                st_d.seq   = SEQ_IDLE;
                st_d.code  = slot_stat_q;
            end
        end

        if (cmpl_valid) begin
            if (st_d.stat[STAT_INT_BIT]) begin
                capture = 1'b1;
            end else begin
                st_d.stat  = REPORT_STAT;
                st_d.cause = CAUSE_BSVC;
                st_d.seq   = SEQ_IDLE;
                st_d.code  = cmpl_status;
            end
        end

        if (act.clr_cause) st_d.cause = '0;
        if (act.set_rst)   st_d.cause = CAUSE_RST;
        if (act.raise)     st_d.stat[STAT_INT_BIT] = 1'b1;

        if (ev_set) begin
            st_d.cause                = st_d.cause | ev_cause;
            st_d.stat[DATA_W-2:0]     = st_d.stat[DATA_W-2:0] | ev_stat;
            st_d.stat[STAT_INT_BIT]   = 1'b1;
        end

        st_d.irq = st_d.stat[STAT_INT_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq           = st_q.irq;
    assign rd_data       = st_q.cause;
    assign status        = st_q.stat;
    assign seq_step      = st_q.seq;
    assign cmpl_code     = st_q.code;
    assign defer_pending = slot_pend_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_cause,
    input logic       ev_set,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       rpt_dis,
    input logic       cmpl_valid,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic [2:0] seq_step,
    input logic       defer_pending
);
    logic quiet_rd;
    assign quiet_rd = rd_cause && !ev_set && !cmd_valid && !cmpl_valid && !defer_pending;

    p_irq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !rd_cause |=> irq);

    p_cause_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_rd |=> rd_data == 8'h00);

    p_read_lowers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_rd |=> !irq && seq_step == 3'b100);

    p_defer_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid && irq && !rd_cause |=> defer_pending);

    p_replay_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause && defer_pending |=> irq);

    p_rst_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'b01 && rpt_dis && !irq && !ev_set
        && !cmpl_valid && !(rd_cause && defer_pending) |=> !irq);

    p_read_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause && ev_set |=> irq);
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_cause      (rd_cause),
    .ev_set        (ev_set),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .rpt_dis       (rpt_dis),
    .cmpl_valid    (cmpl_valid),
    .irq           (irq),
    .rd_data       (rd_data),
    .seq_step      (seq_step),
    .defer_pending (defer_pending)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_cause = 1'b0, ev_set = 1'b0, cmd_valid = 1'b0, rpt_dis = 1'b0, cmpl_valid = 1'b0;
    logic [7:0] ev_cause = '0, cmpl_status = '0;
    logic [6:0] ev_stat = '0;
    logic [1:0] cmd_op = '0;
    logic       irq, defer_pending;
    logic [7:0] rd_data, status, cmpl_code;
    logic [2:0] seq_step;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0, cmp_en = 0;

    // reference model state
    int m_cause = 0, m_stat = 0, m_seq = 0, m_code = 0, m_pend = 0, m_pstat = 0;

    irq_status_unit u_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .rd_cause(rd_cause), .ev_set(ev_set),
        .ev_cause(ev_cause), .ev_stat(ev_stat), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .rpt_dis(rpt_dis), .cmpl_valid(cmpl_valid),
        .cmpl_status(cmpl_status), .irq(irq), .rd_data(rd_data),
        .status(status), .seq_step(seq_step), .cmpl_code(cmpl_code),
        .defer_pending(defer_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model: applies the per-cycle order read, replay, completion, command, event.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cause = 0; m_stat = 0; m_seq = 0; m_code = 0; m_pend = 0; m_pstat = 0;
        end else begin
            if (rd_cause) begin
                m_cause = 0;
                m_stat  = m_stat & 'h6F;
                m_seq   = 4;
                if (m_pend != 0) begin
                    m_stat = 'h93; m_cause = 'h10; m_seq = 0; m_code = m_pstat; m_pend = 0;
                end
            end
            if (cmpl_valid) begin
                if ((m_stat & 'h80) != 0) begin
                    m_pend = 1; m_pstat = int'(cmpl_status);
                end else begin
                    m_stat = 'h93; m_cause = 'h10; m_seq = 0; m_code = int'(cmpl_status);
                end
            end
            if (cmd_valid) begin
                case (cmd_op)
                    2'b01: begin m_cause = 'h80; if (!rpt_dis) m_stat = m_stat | 'h80; end
                    2'b10: m_cause = 0;
                    2'b11: begin m_cause = 0; m_stat = m_stat | 'h80; end
                    default: ;
                endcase
            end
            if (ev_set) begin
                m_cause = m_cause | int'(ev_cause);
                m_stat  = m_stat | int'(ev_stat) | 'h80;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (cmp_en) begin
            chk("R2 model irq", int'(irq), (m_stat >> 7) & 1);
            chk("R3 model cause", int'(rd_data), m_cause);
            chk("R4 model status", int'(status), m_stat);
            chk("R4 model seq", int'(seq_step), m_seq);
            chk("R6 model defer", int'(defer_pending), m_pend);
            chk("R7 model code", int'(cmpl_code), m_code);
        end
        if (cycles > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected <50000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle();
        rd_cause = 0; ev_set = 0; cmd_valid = 0; cmpl_valid = 0;
        ev_cause = 0; ev_stat = 0; cmd_op = 0; cmpl_status = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic ack();
        rd_cause = 1; tick();
    endtask

    initial begin
        bit [31:0] lfsr = 32'h1ACE_B00C;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        chk("R1 irq", int'(irq), 0);
        chk("R1 cause", int'(rd_data), 0);
        chk("R1 status", int'(status), 0);
        chk("R1 seq", int'(seq_step), 0);
        chk("R1 defer", int'(defer_pending), 0);
        cmp_en = 1;

        // R5/R2 event raise
        ev_set = 1; ev_cause = 8'h08; ev_stat = 7'h10; tick();
        chk("R2 irq high", int'(irq), 1);
        chk("R5 cause", int'(rd_data), 'h08);
        chk("R5 status", int'(status), 'h90);
        tick();
        chk("R2 irq held", int'(irq), 1);

        // R3/R4 read
        rd_cause = 1;
        chk("R3 rd_data during read", int'(rd_data), 'h08);
        tick();
        chk("R3 cause cleared", int'(rd_data), 0);
        chk("R4 status cleared", int'(status), 0);
        chk("R4 seq done", int'(seq_step), 4);
        chk("R4 irq low", int'(irq), 0);

        // R4 phase bits survive
        ev_set = 1; ev_cause = 8'h20; ev_stat = 7'h05; tick();
        ack();
        chk("R4 other bits kept", int'(status), 'h05);

        // R7 immediate completion
        cmpl_valid = 1; cmpl_status = 8'h02; tick();
        chk("R7 status", int'(status), 'h93);
        chk("R7 cause", int'(rd_data), 'h10);
        chk("R7 seq", int'(seq_step), 0);
        chk("R7 code", int'(cmpl_code), 'h02);

        // R6 deferred completion
        cmpl_valid = 1; cmpl_status = 8'hA5; tick();
        chk("R6 defer set", int'(defer_pending), 1);
        chk("R6 code unchanged", int'(cmpl_code), 'h02);
        chk("R6 status unchanged", int'(status), 'h93);

        // R8 replay on read
        ack();
        chk("R8 irq again", int'(irq), 1);
        chk("R8 code", int'(cmpl_code), 'hA5);
        chk("R8 defer cleared", int'(defer_pending), 0);
        chk("R8 cause", int'(rd_data), 'h10);
        chk("R8 seq", int'(seq_step), 0);
        ack();
        chk("R8 second read lowers", int'(irq), 0);

        // R9 bus reset gating
        rpt_dis = 1; cmd_valid = 1; cmd_op = 2'b01; tick();
        chk("R9 cause rst", int'(rd_data), 'h80);
        chk("R9 suppressed", int'(irq), 0);
        rpt_dis = 0; cmd_valid = 1; cmd_op = 2'b01; tick();
        chk("R9 raised", int'(irq), 1);
        ack();

        // R10 selection commands
        ev_set = 1; ev_cause = 8'h04; tick();
        ack();
        cmd_valid = 1; cmd_op = 2'b11; tick();
        chk("R10 disable raises", int'(irq), 1);
        chk("R10 disable zeroes", int'(rd_data), 0);
        ack();
        ev_set = 1; ev_cause = 8'h40; tick();
        cmd_valid = 1; cmd_op = 2'b10; tick();
        chk("R10 enable zeroes", int'(rd_data), 0);
        chk("R10 enable keeps irq", int'(irq), 1);
        ack();
        cmd_valid = 1; cmd_op = 2'b00; tick();
        chk("R10 none irq", int'(irq), 0);
        chk("R10 none seq", int'(seq_step), 4);

        // R11 read and raise in one cycle
        ev_set = 1; ev_cause = 8'h01; tick();
        rd_cause = 1; ev_set = 1; ev_cause = 8'h02; tick();
        chk("R11 irq stays", int'(irq), 1);
        chk("R11 cause new only", int'(rd_data), 'h02);
        chk("R11 seq done", int'(seq_step), 4);

        // R12 read and completion in one cycle, nothing parked
        rd_cause = 1; cmpl_valid = 1; cmpl_status = 8'h3C; tick();
        chk("R12 not deferred", int'(defer_pending), 0);
        chk("R12 reported", int'(cmpl_code), 'h3C);
        chk("R12 status", int'(status), 'h93);
        ack();

        // mixed pseudo-random phase
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rd_cause    = lfsr[0] & lfsr[5];
            ev_set      = lfsr[1] & lfsr[7] & lfsr[9];
            ev_cause    = lfsr[15:8];
            ev_stat     = lfsr[22:16];
            cmd_valid   = lfsr[2] & lfsr[11];
            cmd_op      = lfsr[4:3];
            rpt_dis     = lfsr[23];
            cmpl_valid  = lfsr[6] & lfsr[12];
            cmpl_status = lfsr[31:24];
            @(negedge clk);
        end
        idle();
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule